// File: doc/BRIEF.md
# Three-Wire Memory Card Line Symbol Decoder

This block listens, without driving anything, to the three lines of a synchronous memory card bus: a card reset line, a card clock line and a bidirectional data line. It oversamples all three with a faster system clock, resynchronises them, and turns their relative timing into line-level symbols. These symbols are a reset or an interrupt, START and STOP conditions, single data bits, and assembled bytes. Each symbol is reported as a one-cycle strobe.

A transaction layer sits above the decoder and knows whether the bus is carrying outgoing card data or an internal processing phase. It drives a gating input that hides START and STOP conditions during those phases. A configuration input keeps START visible anyway, so that the upper layer can regain framing after losing track of a read. The block does not interpret commands, count transfer lengths or store data beyond the last byte.

Top module: `mcard_sym_decoder`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it, every strobe output is low and `byte_data_o` reads 0.
- R2: A card reset window is one that opens on a rising `card_rst_i` and closes on its falling edge. If it contains a complete card clock pulse (a rise followed by a fall), `reset_sym_o` pulses for one cycle. The strobe comes three system clocks after the card reset line falls, because of two synchroniser flops and one output register.
- R3: A card reset window with no complete card clock pulse inside it pulses `intr_sym_o` instead, with the same latency. A clock that only rose inside the window does not count.
- R4: With the card reset line low, a falling data line while the card clock is high pulses `start_sym_o`, three system clocks after the data line change.
- R5: With the card reset line low, a rising data line while the card clock is high pulses `stop_sym_o`.
- R6: With the card reset line low, the data line value seen at a card clock rise is a bit. That bit is reported on `bit_value_o` with a `bit_valid_o` pulse when the card clock next falls.
- R7: `bit_index_o` gives the position of each reported bit within its byte, from 0 to 7. Bits are received least significant first.
- R8: When the eighth bit is reported, `byte_valid_o` pulses together with `bit_valid_o`. The first received bit lands in bit 0 of `byte_data_o`, and the next bit starts a new byte at index 0. `byte_data_o` holds its value until the next byte.
- R9: While the card reset line is high, no START, STOP or bit is reported, whatever the other two lines do.
- R10: A partly collected byte is dropped at a reset or interrupt, at an accepted START or STOP, and at a card clock fall with no open bit. The next byte then starts at index 0.
- R11: While `xfer_gate_i` is high, STOP is never reported. START is reported only if `start_resync_en_i` is high.
- R12: If the data line edge and the card clock rise land in the same synchronised sample, the START or STOP condition wins. No bit opens, and the following clock fall reports nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the card lines |
| rst | input | 1 | Synchronous active-high reset |
| card_rst_i | input | 1 | Card reset line, active high, asynchronous |
| card_clk_i | input | 1 | Card clock line, asynchronous |
| card_io_i | input | 1 | Card data line, asynchronous |
| xfer_gate_i | input | 1 | High during outgoing data or processing phases; hides START/STOP |
| start_resync_en_i | input | 1 | Keeps START visible while gated |
| reset_sym_o | output | 1 | Reset symbol strobe |
| intr_sym_o | output | 1 | Interrupt symbol strobe |
| start_sym_o | output | 1 | START condition strobe |
| stop_sym_o | output | 1 | STOP condition strobe |
| bit_valid_o | output | 1 | Bit reported strobe |
| bit_value_o | output | 1 | Value of the reported bit |
| bit_index_o | output | 3 | Position of the reported bit in its byte |
| byte_valid_o | output | 1 | Byte complete strobe |
| byte_data_o | output | 8 | Last assembled byte |

## Verification
The bench sends a reset window with a clock pulse, one with a clock that rose but never fell, and one with no clock at all. A design that only counts clock edges would report a reset where an interrupt belongs. It breaks bytes off after a few bits with START and with an interrupt, and then checks that the next byte still decodes in full; a design that keeps the stale bit count would misalign every later byte. It toggles the data line under a high clock while the card reset is high, and while the gate is set with and without the resync option, to catch symbols that leak through. It also moves the data line and clock in the same sample, where a design with the wrong priority would open a phantom bit.

// File: rtl/mcsd_pkg.sv
package mcsd_pkg;

    typedef struct packed {
        logic rst;
        logic clk;
        logic io;
    } line_t;

    typedef struct packed {
        logic rst_rise;
        logic rst_fall;
        logic clk_rise;
        logic clk_fall;
        logic io_rise;
        logic io_fall;
    } edge_t;

    typedef enum logic [1:0] {
        RW_IDLE,
        RW_WAIT_RISE,
        RW_WAIT_FALL,
        RW_PULSED
    } rw_state_e;

    function automatic edge_t find_edges(line_t cur, line_t prev);
        edge_t e;
        e.rst_rise = cur.rst & ~prev.rst;
        e.rst_fall = ~cur.rst & prev.rst;
        e.clk_rise = cur.clk & ~prev.clk;
        e.clk_fall = ~cur.clk & prev.clk;
        e.io_rise  = cur.io & ~prev.io;
        e.io_fall  = ~cur.io & prev.io;
        return e;
    endfunction

endpackage

// File: rtl/mcsd_sync.sv
module mcsd_sync
    import mcsd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  line_t line_i,
    output line_t cur_o,
    output line_t prev_o
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0][2:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[DEPTH-2:0], line_i};
        end
    end

    assign cur_o  = stage_q[SYNC_STAGES-1];
    assign prev_o = stage_q[SYNC_STAGES];
endmodule

// File: rtl/mcsd_rst_window.sv
module mcsd_rst_window
    import mcsd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cur_rst_i,
    input  logic rst_rise_i,
    input  logic rst_fall_i,
    input  logic clk_rise_i,
    input  logic clk_fall_i,
    output logic reset_sym_o,
    output logic intr_sym_o
);
    rw_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= RW_IDLE;
            reset_sym_o <= 1'b0;
            intr_sym_o  <= 1'b0;
        end else begin
            reset_sym_o <= 1'b0;
            intr_sym_o  <= 1'b0;
            if (rst_rise_i) begin
                state_q <= RW_WAIT_RISE;
            end else if (rst_fall_i) begin
                reset_sym_o <= (state_q == RW_PULSED);
                intr_sym_o  <= (state_q != RW_PULSED);
                state_q     <= RW_IDLE;
            end else if (cur_rst_i) begin
                if (state_q == RW_WAIT_RISE && clk_rise_i) begin
                    state_q <= RW_WAIT_FALL;
                end else if (state_q == RW_WAIT_FALL && clk_fall_i) begin
                    state_q <= RW_PULSED;
                end
            end
        end
    end
endmodule

// File: rtl/mcsd_cond_detect.sv
module mcsd_cond_detect (
    input  logic clk,
    input  logic rst,
    input  logic quiet_i,
    input  logic clk_high_i,
    input  logic io_rise_i,
    input  logic io_fall_i,
    input  logic gate_i,
    input  logic resync_en_i,
    output logic start_take_o,
    output logic stop_take_o,
    output logic start_sym_o,
    output logic stop_sym_o
);
    logic cond_window;

    assign cond_window  = quiet_i & clk_high_i;
    assign start_take_o = cond_window & io_fall_i & (~gate_i | resync_en_i);
    assign stop_take_o  = cond_window & io_rise_i & ~gate_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_sym_o <= 1'b0;
            stop_sym_o  <= 1'b0;
        end else begin
            start_sym_o <= start_take_o;
            stop_sym_o  <= stop_take_o;
        end
    end
endmodule

// File: rtl/mcsd_bit_asm.sv
module mcsd_bit_asm #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              quiet_i,
    input  logic              flush_i,
    input  logic              clk_rise_i,
    input  logic              clk_fall_i,
    input  logic              io_i,
    output logic              bit_valid_o,
    output logic              bit_value_o,
    output logic [IDX_W-1:0]  bit_index_o,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_data_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

    logic              open_q;
    logic              val_q;
    logic [IDX_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] shift_nx;

    assign shift_nx = {val_q, shift_q[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q       <= 1'b0;
            val_q        <= 1'b0;
            cnt_q        <= '0;
            shift_q      <= '0;
            bit_valid_o  <= 1'b0;
            bit_value_o  <= 1'b0;
            bit_index_o  <= '0;
            byte_valid_o <= 1'b0;
            byte_data_o  <= '0;
        end else begin
            bit_valid_o  <= 1'b0;
            byte_valid_o <= 1'b0;
            if (flush_i) begin
                open_q <= 1'b0;
                cnt_q  <= '0;
            end else if (quiet_i) begin
                if (clk_rise_i) begin
                    open_q <= 1'b1;
                    val_q  <= io_i;
                end else if (clk_fall_i) begin
                    open_q <= 1'b0;
                    if (open_q) begin
                        bit_valid_o <= 1'b1;
                        bit_value_o <= val_q;
                        bit_index_o <= cnt_q;
                        shift_q     <= shift_nx;
                        if (cnt_q == LAST_IDX) begin
                            byte_valid_o <= 1'b1;
                            byte_data_o  <= shift_nx;
                            cnt_q        <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mcard_sym_decoder.sv
module mcard_sym_decoder
    import mcsd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       card_rst_i,
    input  logic                       card_clk_i,
    input  logic                       card_io_i,
    input  logic                       xfer_gate_i,
    input  logic                       start_resync_en_i,
    output logic                       reset_sym_o,
    output logic                       intr_sym_o,
    output logic                       start_sym_o,
    output logic                       stop_sym_o,
    output logic                       bit_valid_o,
    output logic                       bit_value_o,
    output logic [$clog2(BYTE_W)-1:0]  bit_index_o,
    output logic                       byte_valid_o,
    output logic [BYTE_W-1:0]          byte_data_o
);
    localparam int IDX_W = $clog2(BYTE_W);

    line_t line_in;
    line_t samp_cur;
    line_t samp_prev;
    edge_t edg;
    logic  quiet;
    logic  start_take;
    logic  stop_take;
    logic  flush;
    logic  sync_rst_cur;
    logic  sync_rst_prev;

    assign line_in = '{rst: card_rst_i, clk: card_clk_i, io: card_io_i};

    mcsd_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_in),
        .cur_o  (samp_cur),
        .prev_o (samp_prev)
    );

    assign edg           = find_edges(samp_cur, samp_prev);
    assign sync_rst_cur  = samp_cur.rst;
    assign sync_rst_prev = samp_prev.rst;
    assign quiet         = ~sync_rst_cur & ~sync_rst_prev;
    assign flush         = edg.rst_rise | edg.rst_fall | start_take | stop_take;

    mcsd_rst_window rw_i (
        .clk         (clk),
        .rst         (rst),
        .cur_rst_i   (sync_rst_cur),
        .rst_rise_i  (edg.rst_rise),
        .rst_fall_i  (edg.rst_fall),
        .clk_rise_i  (edg.clk_rise),
        .clk_fall_i  (edg.clk_fall),
        .reset_sym_o (reset_sym_o),
        .intr_sym_o  (intr_sym_o)
    );

    mcsd_cond_detect cond_i (
        .clk          (clk),
        .rst          (rst),
        .quiet_i      (quiet),
        .clk_high_i   (samp_cur.clk),
        .io_rise_i    (edg.io_rise),
        .io_fall_i    (edg.io_fall),
        .gate_i       (xfer_gate_i),
        .resync_en_i  (start_resync_en_i),
        .start_take_o (start_take),
        .stop_take_o  (stop_take),
        .start_sym_o  (start_sym_o),
        .stop_sym_o   (stop_sym_o)
    );

    mcsd_bit_asm #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) asm_i (
        .clk          (clk),
        .rst          (rst),
        .quiet_i      (quiet),
        .flush_i      (flush),
        .clk_rise_i   (edg.clk_rise),
        .clk_fall_i   (edg.clk_fall),
        .io_i         (samp_cur.io),
        .bit_valid_o  (bit_valid_o),
        .bit_value_o  (bit_value_o),
        .bit_index_o  (bit_index_o),
        .byte_valid_o (byte_valid_o),
        .byte_data_o  (byte_data_o)
    );
endmodule

// File: rtl/mcsd_checker.sv
module mcsd_checker #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cur_rst,
    input logic             prev_rst,
    input logic             gate,
    input logic             reset_sym,
    input logic             intr_sym,
    input logic             start_sym,
    input logic             stop_sym,
    input logic             bit_valid,
    input logic             byte_valid,
    input logic [IDX_W-1:0] bit_index
);
    a_r9_quiet_in_rst: assert property (@(posedge clk) disable iff (rst)
        (cur_rst && prev_rst) |=> !(start_sym || stop_sym || bit_valid));

    a_r11_gate_stop: assert property (@(posedge clk) disable iff (rst)
        gate |=> !stop_sym);

    a_r8_byte_last: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> (bit_valid && bit_index == IDX_W'(BYTE_W - 1)));

    a_r4_one_symbol: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reset_sym, intr_sym, start_sym, stop_sym, bit_valid}));

    a_r10_start_flush: assert property (@(posedge clk) disable iff (rst)
        start_sym |=> !bit_valid);

    a_r2_sym_at_fall: assert property (@(posedge clk) disable iff (rst)
        (reset_sym || intr_sym) |-> ($past(prev_rst) && !$past(cur_rst)));
endmodule

bind mcard_sym_decoder mcsd_checker #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cur_rst    (sync_rst_cur),
    .prev_rst   (sync_rst_prev),
    .gate       (xfer_gate_i),
    .reset_sym  (reset_sym_o),
    .intr_sym   (intr_sym_o),
    .start_sym  (start_sym_o),
    .stop_sym   (stop_sym_o),
    .bit_valid  (bit_valid_o),
    .byte_valid (byte_valid_o),
    .bit_index  (bit_index_o)
);

// File: tb/mcard_sym_decoder_tb.sv
`timescale 1ns/1ps
module mcard_sym_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       l_rst = 1'b0, l_clk = 1'b0, l_io = 1'b0;
    logic       gate = 1'b0, resync = 1'b0;
    logic       reset_sym, intr_sym, start_sym, stop_sym;
    logic       bit_valid, bit_value, byte_valid;
    logic [2:0] bit_index;
    logic [7:0] byte_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    mcard_sym_decoder dut_i (
        .clk(clk), .rst(rst),
        .card_rst_i(l_rst), .card_clk_i(l_clk), .card_io_i(l_io),
        .xfer_gate_i(gate), .start_resync_en_i(resync),
        .reset_sym_o(reset_sym), .intr_sym_o(intr_sym),
        .start_sym_o(start_sym), .stop_sym_o(stop_sym),
        .bit_valid_o(bit_valid), .bit_value_o(bit_value),
        .bit_index_o(bit_index), .byte_valid_o(byte_valid),
        .byte_data_o(byte_data)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [2:0] hist[$];
    bit m_rose, m_pulse, m_open, m_val;
    bit m_bits[$];
    bit e_reset, e_intr, e_start, e_stop, e_bit, e_bval, e_byte;
    int e_idx, e_data;

    always @(posedge clk) begin
        bit cr, cc, ci, pr, pc, pi;
        e_reset = 0; e_intr = 0; e_start = 0; e_stop = 0; e_bit = 0; e_byte = 0;
        if (rst) begin
            hist.delete(); m_bits.delete();
            m_rose = 0; m_pulse = 0; m_open = 0; m_val = 0;
            e_bval = 0; e_idx = 0; e_data = 0;
        end else begin
            hist.push_back({l_rst, l_clk, l_io});
            if (hist.size() > 8) void'(hist.pop_front());
            {cr, cc, ci} = (hist.size() >= 3) ? hist[hist.size()-3] : 3'b000;
            {pr, pc, pi} = (hist.size() >= 4) ? hist[hist.size()-4] : 3'b000;
            if (cr && !pr) begin
                m_rose = 0; m_pulse = 0; m_open = 0; m_bits.delete();
            end else if (!cr && pr) begin
                if (m_pulse) e_reset = 1; else e_intr = 1;
                m_rose = 0; m_pulse = 0; m_open = 0; m_bits.delete();
            end else if (cr) begin
                if (cc && !pc) m_rose = 1;
                if (!cc && pc && m_rose) m_pulse = 1;
            end else begin
                if (cc && pi && !ci && (!gate || resync)) begin
                    e_start = 1; m_open = 0; m_bits.delete();
                end else if (cc && !pi && ci && !gate) begin
                    e_stop = 1; m_open = 0; m_bits.delete();
                end else if (cc && !pc) begin
                    m_open = 1; m_val = ci;
                end else if (!cc && pc) begin
                    if (m_open) begin
                        e_bit = 1; e_bval = m_val; e_idx = m_bits.size();
                        m_bits.push_back(m_val);
                        if (m_bits.size() == 8) begin
                            e_byte = 1; e_data = 0;
                            foreach (m_bits[k]) e_data |= int'(m_bits[k]) << k;
                            m_bits.delete();
                        end
                    end else begin
                        m_bits.delete();
                    end
                    m_open = 0;
                end
            end
        end
    end

    int c_reset, c_intr, c_start, c_stop, c_bit, c_byte, last_byte;

    always @(negedge clk) begin
        if (!rst && hist.size() > 0) begin
            check("R2 reset_sym", reset_sym, e_reset);
            check("R3 intr_sym", intr_sym, e_intr);
            check("R4 start_sym", start_sym, e_start);
            check("R5 stop_sym", stop_sym, e_stop);
            check("R6 bit_valid", bit_valid, e_bit);
            check("R8 byte_valid", byte_valid, e_byte);
            if (e_bit) begin
                check("R6 bit_value", bit_value, e_bval);
                check("R7 bit_index", bit_index, e_idx);
            end
            if (e_byte) check("R8 byte_data", byte_data, e_data);
            c_reset += reset_sym; c_intr += intr_sym;
            c_start += start_sym; c_stop += stop_sym;
            c_bit += bit_valid; c_byte += byte_valid;
            if (byte_valid) last_byte = byte_data;
        end
    end

    task automatic clr();
        c_reset = 0; c_intr = 0; c_start = 0; c_stop = 0; c_bit = 0; c_byte = 0;
    endtask

    task automatic step(bit r, bit c, bit i, int n);
        @(negedge clk);
        l_rst = r; l_clk = c; l_io = i;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic send_bits(logic [7:0] b, int nbits);
        for (int k = 0; k < nbits; k++) begin
            step(0, 0, b[k], 3);
            step(0, 1, b[k], 3);
            step(0, 0, b[k], 3);
        end
    endtask

    task automatic do_start();
        step(0, 0, 1, 3); step(0, 1, 1, 3); step(0, 1, 0, 3); step(0, 0, 0, 3);
    endtask

    task automatic do_stop();
        step(0, 0, 0, 3); step(0, 1, 0, 3); step(0, 1, 1, 3); step(0, 0, 1, 3);
    endtask

    initial begin
        clr();
        last_byte = -1;
        repeat (4) @(negedge clk);
        check("R1 reset strobes", {reset_sym, intr_sym, start_sym, stop_sym, bit_valid, byte_valid}, 0);
        check("R1 reset byte_data", byte_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 first cycle strobes", {reset_sym, intr_sym, start_sym, stop_sym, bit_valid, byte_valid}, 0);

        // R2: reset window with a full clock pulse, then a byte
        clr();
        step(0, 0, 1, 3); step(1, 0, 1, 4); step(1, 1, 1, 4); step(1, 0, 1, 4); step(0, 0, 1, 6);
        check("R2 reset count", c_reset, 1);
        check("R2 no intr", c_intr, 0);
        send_bits(8'hA5, 8); step(0, 0, 1, 4);
        check("R6 bit count", c_bit, 8);
        check("R8 byte count", c_byte, 1);
        check("R8 byte value", last_byte, 8'hA5);

        // R3: clock rose but never fell inside window, then no clock at all
        clr();
        step(1, 0, 1, 4); step(1, 1, 1, 4); step(0, 1, 1, 4); step(0, 0, 1, 6);
        step(1, 0, 1, 4); step(0, 0, 1, 6);
        check("R3 intr count", c_intr, 2);
        check("R3 no reset", c_reset, 0);
        check("R3 no bit", c_bit, 0);

        // R4/R5/R7: START, byte, STOP
        clr();
        do_start(); send_bits(8'h3C, 8); do_stop(); step(0, 0, 1, 4);
        check("R4 start count", c_start, 1);
        check("R5 stop count", c_stop, 1);
        check("R7 byte value", last_byte, 8'h3C);

        // R10: partial bytes dropped at START and at interrupt
        clr();
        do_start(); send_bits(8'h07, 3); do_start(); send_bits(8'h81, 8); step(0, 0, 1, 4);
        check("R10 start drop bytes", c_byte, 1);
        check("R10 start drop value", last_byte, 8'h81);
        send_bits(8'h1F, 5); step(1, 0, 1, 4); step(0, 0, 1, 6);
        send_bits(8'h5A, 8); step(0, 0, 1, 4);
        check("R10 intr drop bytes", c_byte, 2);
        check("R10 intr drop value", last_byte, 8'h5A);

        // R11: gating with and without resync
        clr();
        gate = 1'b1;
        do_start(); do_stop(); step(0, 0, 1, 4);
        check("R11 gated start", c_start, 0);
        check("R11 gated stop", c_stop, 0);
        resync = 1'b1;
        do_start(); do_stop(); step(0, 0, 1, 4);
        check("R11 resync start", c_start, 1);
        check("R11 resync stop", c_stop, 0);
        gate = 1'b0; resync = 1'b0;
        step(0, 0, 1, 4);

        // R12: data edge and clock rise in the same sample
        clr();
        step(0, 0, 1, 4); step(0, 1, 0, 4); step(0, 0, 0, 6);
        check("R12 start wins", c_start, 1);
        check("R12 no phantom bit", c_bit, 0);

        // R9: data toggling under high clock while reset is high
        clr();
        step(0, 0, 1, 4); step(1, 0, 1, 4); step(1, 1, 1, 4); step(1, 1, 0, 4);
        step(1, 1, 1, 4); step(1, 0, 1, 4); step(0, 0, 1, 6);
        check("R9 no start", c_start, 0);
        check("R9 no stop", c_stop, 0);
        check("R9 no bit", c_bit, 0);
        check("R9 reset seen", c_reset, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule